// File: doc/BRIEF.md
# Cache test register access unit

This block gives software a test window into a 4-way set-associative cache whose lines carry a 2-bit coherence state (invalid, exclusive, modified, shared). Three 32-bit registers are visible: a data word, a status word and a control word. A write to the control word carries an operation code and starts that operation on the same clock edge. Four operations exist: a read-buffer read, an array line write, an array line read, and a flush of all state. Writing the data word while the stored operation code is the buffer code places the word into one slot of a 128-bit fill line. A cache write copies that line, together with the tag held in the status word, into the chosen way. A cache read loads a 128-bit read line and fills the status word with the tag, the valid bits and the replacement bits of the set.

A strap input picks write-back or write-through behaviour. It is captured while reset is asserted and is then held. A parameter picks the small geometry (8 Kbyte, 128 sets) or the large geometry (16 Kbyte, 256 sets). In write-back mode an extension bit in the control word switches the status word from the tag view to a view of the per-way states. Software can tell the two geometries apart through status bit 11.

Top module: `cache_test_port`

## Requirements
- R1: After reset the data, status and control words read 0, every way in every set is invalid, and all replacement bits are 0.
- R2: Register select codes are 0 = data, 1 = status, 2 = control. A data write stores the word in the data register. If control bits 1..0 hold 00 (the buffer code), the word also goes into fill-line slot number control bits 3..2. A control write with code 00 loads the data register with read-line slot number bits 3..2.
- R3: A control write with code 01 stores the fill line and the status tag in way (bits 3..2) of the set selected by the index field. It also stores the way's state.
- R4: A control write with code 10 loads the read line from the selected way. It also loads the status word: the tag in bits 31..11, that way's valid bit in bit 10, the set's replacement bits in 9..7, the set's four valid bits in 6..3 (bit 3 is way 0), and zeros in 2..0.
- R5: The index field is control bits 10..4 for the small geometry and bits 11..4 for the large one. For the small geometry, bit 11 of the control word selects nothing.
- R6: In write-back mode a cache write stores the state from control bits 18..17 (00 invalid, 01 exclusive, 10 modified, 11 shared) and ignores status bit 10. A way is valid whenever its state is not 00.
- R7: In write-back mode with control bit 19 set, the status word shows: the state of the way last read in bits 30..29, the states of ways 3 down to 0 in bits 27..20 (way 3 in 27..26), zeros in bits 31, 28 and 19..11, and bits 10..0 as in R4.
- R8: In write-through mode a cache write marks the way valid (state 01) when status bit 10 is 1 and invalid otherwise. Control bits 19..17 read 0 and ignore writes, and the status word always shows the tag view.
- R9: A status write updates bits 31..10 only. Bits 9..3 keep the values from the last cache read, and bits 2..0 read 0.
- R10: A control write with code 11 clears the state of every way and the replacement bits of every set.
- R11: The replacement bits b2 b1 b0 sit in status bits 9, 8, 7. A write to way w sets b0 = 1 when w < 2. For w < 2 it sets b1 = 1 when w = 0. For w >= 2 it sets b2 = 1 when w = 2. All other bits are kept.
- R12: For the large geometry, status bit 11 reads 0 after a cache read and is an ordinary writable bit otherwise. For the small geometry it is the lowest stored tag bit and returns from a cache read as written.
- R13: The mode is taken from the strap while reset is asserted. Strap changes after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wb_strap | input | 1 | 1 = write-back, 0 = write-through, sampled during reset |
| reg_wr | input | 1 | Register write strobe, one word per cycle |
| reg_sel | input | 2 | Register select: 0 data, 1 status, 2 control, 3 none |
| reg_wdata | input | 32 | Write word |
| data_rd | output | 32 | Current data register |
| status_rd | output | 32 | Current status register view |
| control_rd | output | 32 | Current control register |

## Verification
The assertions assume a single register write per cycle and a strap held steady while reset is low. They also assume the index and way presented with a control write are the ones that write acts on. The stimulus writes one register and then leaves a quiet cycle, so each result is sampled on the falling edge after the capturing edge. Tags are compared only for ways that were written since reset, because the tag and data arrays carry no reset. The stimulus keeps control bit 11 at 0 wherever both geometries must agree.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int NUM_WAYS   = 4;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;

  localparam logic [1:0] OP_BUF   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_FLUSH = 2'b11;

  localparam logic [1:0] ST_INV = 2'b00;
  localparam logic [1:0] ST_EXC = 2'b01;

  localparam int EXT_BIT = 19;
  localparam int SST_LO  = 17;

  // tree replacement: b0 picks the pair, b1/b2 pick inside the pair
  function automatic logic [2:0] plru_touch(input logic [2:0] cur, input logic [1:0] way);
    logic [2:0] nxt;
    nxt    = cur;
    nxt[0] = ~way[1];
    if (!way[1]) nxt[1] = ~way[0];
    else         nxt[2] = ~way[0];
    return nxt;
  endfunction
endpackage

// File: rtl/ctp_line_buffers.sv
module ctp_line_buffers #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int SEL_W  = $clog2(WORDS),
  localparam int LINE_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we,
  input  logic [SEL_W-1:0]  fill_sel,
  input  logic [WORD_W-1:0] fill_word,
  input  logic              load_rd,
  input  logic [LINE_W-1:0] rd_line_in,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [LINE_W-1:0] fill_line,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] fill_q [WORDS];
  logic [LINE_W-1:0] rd_q;

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  fill_q[g] <= '0;
      else if (fill_we && fill_sel == SEL_W'(g))   fill_q[g] <= fill_word;
    end
    assign fill_line[g*WORD_W +: WORD_W] = fill_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (load_rd) rd_q <= rd_line_in;
  end

  assign rd_word = rd_q[rd_sel*WORD_W +: WORD_W];
endmodule

// File: rtl/ctp_array.sv
module ctp_array import ctp_pkg::*; #(
  parameter int IDX_W  = 7,
  parameter int TAG_W  = 21,
  parameter int LINE_W = 128,
  localparam int WAYS    = NUM_WAYS,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int SETS    = 1 << IDX_W,
  localparam int ENTRIES = SETS * WAYS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wb_mode,
  input  logic                do_write,
  input  logic                do_flush,
  input  logic [IDX_W-1:0]    idx,
  input  logic [WAY_W-1:0]    way,
  input  logic [1:0]          wr_state,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [LINE_W-1:0]   wr_line,
  output logic [LINE_W-1:0]   rd_line,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [2*WAYS-1:0]   rd_states,
  output logic [2:0]          rd_lru
);
  logic [LINE_W-1:0]  data_mem [ENTRIES];
  logic [TAG_W-1:0]   tag_mem  [ENTRIES];
  logic [2*WAYS-1:0]  st_arr   [SETS];
  logic [2:0]         lru_arr  [SETS];
  logic [IDX_W+WAY_W-1:0] addr;

  assign addr = {idx, way};

  always_ff @(posedge clk) begin
    if (do_write) begin
      data_mem[addr] <= wr_line;
      tag_mem[addr]  <= wr_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        st_arr[s]  <= '0;
        lru_arr[s] <= '0;
      end
    end else if (do_flush) begin
      for (int s = 0; s < SETS; s++) begin
        st_arr[s]  <= '0;
        lru_arr[s] <= '0;
      end
    end else if (do_write) begin
      st_arr[idx][{way, 1'b0} +: 2] <= wr_state;
      lru_arr[idx]                  <= plru_touch(lru_arr[idx], way);
    end
  end

  assign rd_line   = data_mem[addr];
  assign rd_tag    = tag_mem[addr];
  assign rd_states = st_arr[idx];
  assign rd_lru    = lru_arr[idx];

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    do_flush |=> (st_arr[0] == '0 && lru_arr[0] == 3'b000 &&
                  st_arr[SETS-1] == '0 && lru_arr[SETS-1] == 3'b000)); // R10

  AST_WT_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (do_write && !wb_mode) |=> !st_arr[$past(idx)][2*$past(way)+1]); // R8
endmodule

// File: rtl/ctp_status_view.sv
module ctp_status_view import ctp_pkg::*; (
  input  logic        ext_view,
  input  logic [20:0] tag,
  input  logic        vld,
  input  logic [2:0]  lru,
  input  logic [3:0]  vset,
  input  logic [1:0]  selst,
  input  logic [7:0]  states,
  output logic [31:0] word
);
  always_comb begin
    word       = '0;
    word[10]   = vld;
    word[9:7]  = lru;
    word[6:3]  = vset;
    if (ext_view) begin
      word[30:29] = selst;
      word[27:20] = states;
    end else begin
      word[31:11] = tag;
    end
  end
endmodule

// File: rtl/cache_test_port.sv
module cache_test_port import ctp_pkg::*; #(
  parameter bit GEOM_16K = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wb_strap,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] data_rd,
  output logic [31:0] status_rd,
  output logic [31:0] control_rd
);
  localparam int IDX_W  = GEOM_16K ? 8 : 7;
  localparam int TAG_LO = GEOM_16K ? 12 : 11;
  localparam int TAG_W  = 32 - TAG_LO;
  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int ENT_W  = $clog2(NUM_WAYS);

  logic              wb_q;
  logic [31:0]       data_q;
  logic [20:0]       tag_q;
  logic              vld_q;
  logic [2:0]        lru_q;
  logic [3:0]        vset_q;
  logic [7:0]        states_q;
  logic [1:0]        selst_q;
  logic [1:0]        op_q;
  logic [ENT_W-1:0]  ent_q;
  logic [IDX_W-1:0]  idx_q;
  logic              ext_q;
  logic [1:0]        sst_q;

  logic wr_data_reg, wr_stat, wr_ctl;
  logic do_bufrd, do_write, do_read, do_flush;
  logic [1:0]        op_n;
  logic [ENT_W-1:0]  ent_n;
  logic [IDX_W-1:0]  idx_n;
  logic              ext_n;
  logic [1:0]        sst_n;
  logic [1:0]        wr_state;
  logic [LINE_W-1:0] fill_line, rd_line;
  logic [WORD_W-1:0] rd_word;
  logic [TAG_W-1:0]  rd_tag;
  logic [20:0]       tag_ext;
  logic [7:0]        rd_states;
  logic [2:0]        rd_lru;
  logic [3:0]        rd_vset;
  logic [31:0]       ctl_word;

  // mode strap captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) wb_q <= wb_strap;
  end

  assign wr_data_reg = reg_wr && (reg_sel == SEL_DATA);
  assign wr_stat     = reg_wr && (reg_sel == SEL_STAT);
  assign wr_ctl      = reg_wr && (reg_sel == SEL_CTL);

  assign op_n  = reg_wdata[1:0];
  assign ent_n = reg_wdata[3:2];
  assign idx_n = reg_wdata[4 +: IDX_W];
  assign ext_n = wb_q & reg_wdata[EXT_BIT];
  assign sst_n = wb_q ? reg_wdata[SST_LO +: 2] : 2'b00;

  assign do_bufrd = wr_ctl && (op_n == OP_BUF);
  assign do_write = wr_ctl && (op_n == OP_WRITE);
  assign do_read  = wr_ctl && (op_n == OP_READ);
  assign do_flush = wr_ctl && (op_n == OP_FLUSH);

  assign wr_state = wb_q ? sst_n : (vld_q ? ST_EXC : ST_INV);

  ctp_line_buffers #(.WORD_W(WORD_W), .WORDS(LINE_WORDS)) i_bufs (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_we    (wr_data_reg && (op_q == OP_BUF)),
    .fill_sel   (ent_q),
    .fill_word  (reg_wdata),
    .load_rd    (do_read),
    .rd_line_in (rd_line),
    .rd_sel     (ent_n),
    .fill_line  (fill_line),
    .rd_word    (rd_word)
  );

  ctp_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) i_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_mode   (wb_q),
    .do_write  (do_write),
    .do_flush  (do_flush),
    .idx       (idx_n),
    .way       (ent_n),
    .wr_state  (wr_state),
    .wr_tag    (tag_q[20 -: TAG_W]),
    .wr_line   (fill_line),
    .rd_line   (rd_line),
    .rd_tag    (rd_tag),
    .rd_states (rd_states),
    .rd_lru    (rd_lru)
  );

  // large geometry keeps no tag bit 11: it returns as zero
  assign tag_ext = 21'(rd_tag) << (TAG_LO - 11);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_vld
    assign rd_vset[w] = (rd_states[2*w +: 2] != ST_INV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      tag_q    <= '0;
      vld_q    <= 1'b0;
      lru_q    <= '0;
      vset_q   <= '0;
      states_q <= '0;
      selst_q  <= '0;
      op_q     <= '0;
      ent_q    <= '0;
      idx_q    <= '0;
      ext_q    <= 1'b0;
      sst_q    <= '0;
    end else begin
      if (wr_data_reg)   data_q <= reg_wdata;
      else if (do_bufrd) data_q <= rd_word;

      if (wr_stat) begin
        tag_q <= reg_wdata[31:11];
        vld_q <= reg_wdata[10];
      end else if (do_read) begin
        tag_q    <= tag_ext;
        vld_q    <= rd_vset[ent_n];
        lru_q    <= rd_lru;
        vset_q   <= rd_vset;
        states_q <= rd_states;
        selst_q  <= rd_states[{ent_n, 1'b0} +: 2];
      end

      if (wr_ctl) begin
        op_q  <= op_n;
        ent_q <= ent_n;
        idx_q <= idx_n;
        ext_q <= ext_n;
        sst_q <= sst_n;
      end
    end
  end

  ctp_status_view i_view (
    .ext_view (wb_q && ext_q),
    .tag      (tag_q),
    .vld      (vld_q),
    .lru      (lru_q),
    .vset     (vset_q),
    .selst    (selst_q),
    .states   (states_q),
    .word     (status_rd)
  );

  always_comb begin
    ctl_word                = '0;
    ctl_word[1:0]           = op_q;
    ctl_word[3:2]           = ent_q;
    ctl_word[4 +: IDX_W]    = idx_q;
    ctl_word[EXT_BIT]       = ext_q;
    ctl_word[SST_LO +: 2]   = sst_q;
  end

  assign data_rd    = data_q;
  assign control_rd = ctl_word;

  AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_reg |=> (data_rd == $past(reg_wdata))); // R2

  AST_WT_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_q |-> (control_rd[19:17] == 3'b000)); // R8

  AST_STATUS_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (status_rd[9:3] == $past(status_rd[9:3]))); // R9
endmodule

// File: tb/test_cache_test_port.sv
module test_cache_test_port;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] S_DATA = 2'd0, S_STAT = 2'd1, S_CTL = 2'd2;
  localparam logic [1:0] C_BUF = 2'b00, C_WR = 2'b01, C_RD = 2'b10, C_FL = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wb_strap = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd3;
  logic [31:0] reg_wdata = '0;
  logic [31:0] d8, s8, c8, d16, s16, c16;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_test_port #(.GEOM_16K(1'b0)) i_cache_test_port (
    .clk(clk), .rst_n(rst_n), .wb_strap(wb_strap), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .data_rd(d8), .status_rd(s8), .control_rd(c8));

  cache_test_port #(.GEOM_16K(1'b1)) i_cache_test_port_16k (
    .clk(clk), .rst_n(rst_n), .wb_strap(wb_strap), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .data_rd(d16), .status_rd(s16), .control_rd(c16));

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic ext, input logic [1:0] sst, input logic [7:0] idx,
                                     input logic [1:0] ent, input logic [1:0] op);
    return (32'(ext) << 19) | (32'(sst) << 17) | (32'(idx) << 4) | (32'(ent) << 2) | 32'(op);
  endfunction

  function automatic logic [31:0] st_norm(input logic [20:0] tag, input logic v, input logic [2:0] lru, input logic [3:0] vs);
    return {tag, v, lru, vs, 3'b000};
  endfunction

  function automatic logic [31:0] st_ext(input logic [1:0] sel, input logic [7:0] sts, input logic v,
                                         input logic [2:0] lru, input logic [3:0] vs);
    return {1'b0, sel, 1'b0, sts, 9'b0, v, lru, vs, 3'b000};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] w);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; wb_strap = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "data 8k", d8, 32'h0);
    chk("R1", "status 8k", s8, 32'h0);
    chk("R1", "control 8k", c8, 32'h0);
    chk("R1", "control 16k", c16, 32'h0);
    wr(S_CTL, cw(1'b1, 2'b00, 8'h05, 2'd0, C_RD));
    chk("R1", "state view of fresh set", s8, st_ext(2'b00, 8'h00, 1'b0, 3'b000, 4'b0000));
  endtask

  task automatic t_roundtrip;
    logic [31:0] words [4];
    for (int e = 0; e < 4; e++) words[e] = 32'hC0DE_0000 + 32'(e * 32'h1111);
    for (int e = 0; e < 4; e++) begin
      wr(S_CTL, cw(1'b0, 2'b00, 8'h00, 2'(e), C_BUF));
      wr(S_DATA, words[e]);
      chk("R2", "data word stored", d8, words[e]);
    end
    wr(S_STAT, st_norm(21'h12344, 1'b0, 3'b0, 4'b0));
    wr(S_CTL, cw(1'b0, 2'b01, 8'h03, 2'd1, C_WR));
    wr(S_CTL, cw(1'b0, 2'b00, 8'h03, 2'd1, C_RD));
    chk("R3", "status after line write/read 8k", s8, st_norm(21'h12344, 1'b1, 3'b001, 4'b0010));
    chk("R4", "status after line write/read 16k", s16, st_norm(21'h12344, 1'b1, 3'b001, 4'b0010));
    for (int e = 0; e < 4; e++) begin
      wr(S_CTL, cw(1'b0, 2'b00, 8'h03, 2'(e), C_BUF));
      chk("R4", "read line slot 8k", d8, words[e]);
      chk("R4", "read line slot 16k", d16, words[e]);
    end
  endtask

  task automatic t_wb_states;
    wr(S_STAT, st_norm(21'h0A5A4, 1'b0, 3'b0, 4'b0));
    wr(S_CTL, cw(1'b0, 2'b10, 8'h09, 2'd0, C_WR));
    wr(S_CTL, cw(1'b0, 2'b11, 8'h09, 2'd2, C_WR));
    wr(S_CTL, cw(1'b0, 2'b01, 8'h09, 2'd3, C_WR));
    wr(S_STAT, st_norm(21'h0A5A4, 1'b1, 3'b0, 4'b0));
    wr(S_CTL, cw(1'b0, 2'b00, 8'h09, 2'd1, C_WR));
    wr(S_CTL, cw(1'b1, 2'b00, 8'h09, 2'd2, C_RD));
    chk("R7", "state view 8k", s8, st_ext(2'b11, 8'h72, 1'b1, 3'b001, 4'b1101));
    chk("R7", "state view 16k", s16, st_ext(2'b11, 8'h72, 1'b1, 3'b001, 4'b1101));
    chk("R6", "control keeps ext/state", c8, cw(1'b1, 2'b00, 8'h09, 2'd2, C_RD));
    wr(S_CTL, cw(1'b0, 2'b00, 8'h09, 2'd1, C_RD));
    chk("R6", "status valid bit ignored in write-back", s8, st_norm(21'h0A5A4, 1'b0, 3'b001, 4'b1101));
  endtask

  task automatic t_plru;
    logic [1:0] order [4];
    logic [2:0] expect_lru [4];
    order[0] = 2'd3; order[1] = 2'd1; order[2] = 2'd0; order[3] = 2'd2;
    expect_lru[0] = 3'b000; expect_lru[1] = 3'b001; expect_lru[2] = 3'b011; expect_lru[3] = 3'b110;
    wr(S_STAT, st_norm(21'h12344, 1'b0, 3'b0, 4'b0));
    for (int k = 0; k < 4; k++) begin
      wr(S_CTL, cw(1'b0, 2'b01, 8'h14, order[k], C_WR));
      wr(S_CTL, cw(1'b1, 2'b00, 8'h14, order[k], C_RD));
      chk("R11", "replacement bits", 32'(s8[9:7]), 32'(expect_lru[k]));
    end
  endtask

  task automatic t_status_ro;
    wr(S_STAT, 32'hFFFF_FFFF);
    chk("R9", "status write in state view", s8, st_ext(2'b01, 8'h55, 1'b1, 3'b110, 4'b1111));
    wr(S_CTL, cw(1'b0, 2'b00, 8'h14, 2'd0, C_BUF));
    chk("R9", "status write in tag view 8k", s8, st_norm(21'h1FFFFF, 1'b1, 3'b110, 4'b1111));
    chk("R12", "bit 11 writable outside reads 16k", s16, st_norm(21'h1FFFFF, 1'b1, 3'b110, 4'b1111));
  endtask

  task automatic t_index;
    wr(S_STAT, st_norm(21'h000A0, 1'b0, 3'b0, 4'b0));
    wr(S_CTL, cw(1'b0, 2'b01, 8'h85, 2'd0, C_WR));
    wr(S_STAT, st_norm(21'h000B0, 1'b0, 3'b0, 4'b0));
    wr(S_CTL, cw(1'b0, 2'b01, 8'h05, 2'd0, C_WR));
    wr(S_STAT, st_norm(21'h000C0, 1'b0, 3'b0, 4'b0));
    wr(S_CTL, cw(1'b0, 2'b01, 8'h45, 2'd0, C_WR));
    wr(S_CTL, cw(1'b0, 2'b00, 8'h85, 2'd0, C_RD));
    chk("R5", "control bit 11 not index 8k", 32'(s8[31:11]), 32'h000B0);
    chk("R5", "control bit 11 is index 16k", 32'(s16[31:11]), 32'h000A0);
    wr(S_CTL, cw(1'b0, 2'b00, 8'h05, 2'd0, C_RD));
    chk("R5", "set 05 distinct from 45", 32'(s8[31:11]), 32'h000B0);
  endtask

  task automatic t_geom;
    wr(S_STAT, st_norm(21'h00801, 1'b0, 3'b0, 4'b0));
    wr(S_CTL, cw(1'b0, 2'b01, 8'h30, 2'd0, C_WR));
    wr(S_CTL, cw(1'b0, 2'b00, 8'h30, 2'd0, C_RD));
    chk("R12", "tag bit 11 kept 8k", 32'(s8[31:11]), 32'h00801);
    chk("R12", "tag bit 11 zero 16k", 32'(s16[31:11]), 32'h00800);
  endtask

  task automatic t_flush;
    wr(S_CTL, cw(1'b1, 2'b00, 8'h00, 2'd0, C_FL));
    wr(S_CTL, cw(1'b1, 2'b00, 8'h09, 2'd2, C_RD));
    chk("R10", "set 09 after flush 8k", s8, st_ext(2'b00, 8'h00, 1'b0, 3'b000, 4'b0000));
    chk("R10", "set 09 after flush 16k", s16, st_ext(2'b00, 8'h00, 1'b0, 3'b000, 4'b0000));
    wr(S_CTL, cw(1'b1, 2'b00, 8'h14, 2'd1, C_RD));
    chk("R10", "set 14 after flush", s8, st_ext(2'b00, 8'h00, 1'b0, 3'b000, 4'b0000));
  endtask

  task automatic t_wt;
    do_reset(1'b0);
    wb_strap = 1'b1;
    wr(S_CTL, cw(1'b1, 2'b11, 8'h00, 2'd0, C_BUF));
    chk("R8", "ext/state masked in write-through", c8, 32'h0);
    wr(S_STAT, st_norm(21'h12344, 1'b1, 3'b0, 4'b0));
    wr(S_CTL, cw(1'b1, 2'b11, 8'h07, 2'd0, C_WR));
    wr(S_STAT, st_norm(21'h12344, 1'b0, 3'b0, 4'b0));
    wr(S_CTL, cw(1'b1, 2'b11, 8'h07, 2'd1, C_WR));
    wr(S_CTL, cw(1'b1, 2'b11, 8'h07, 2'd0, C_RD));
    chk("R13", "strap change after reset ignored", s8, st_norm(21'h12344, 1'b1, 3'b001, 4'b0001));
    chk("R8", "control read in write-through", c8, cw(1'b0, 2'b00, 8'h07, 2'd0, C_RD));
    wr(S_CTL, cw(1'b0, 2'b00, 8'h07, 2'd1, C_RD));
    chk("R8", "invalid way from status bit 10", s8, st_norm(21'h12344, 1'b0, 3'b001, 4'b0001));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    t_reset();
    t_roundtrip();
    t_wb_states();
    t_plru();
    t_status_ro();
    t_index();
    t_geom();
    t_flush();
    t_wt();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule